// File: doc/BRIEF.md
# Shadow Memory Region Router

This block decides, for every memory cycle that falls in the upper memory window C0000h–EFFFFh, whether the access is served by local DRAM or passed to the expansion (AT) bus. The window is split into twelve 16 KB blocks. Each block has its own shadow-enable bit. The C, D and E 64 KB segments each have a read-only bit and a source bit that chooses between shadow memory and ROM on the bus. A write aimed at a DRAM-routed block whose segment is read-only is dropped, and a write-inhibit output is raised in its place.

Software loads the configuration through a pair of I/O ports. It first writes a register index to the index port (22h), then reads or writes the register contents at the data port (24h). The routing decode is combinational from the memory address, the write strobe and the stored configuration. Only the configuration and the latched index are held in registers.

Top module: `shadowRouter`

## Requirements
- R1: After reset every configuration register and the latched index read back 0, so each block in the window is routed to the bus.
- R2: An I/O write to port 22h latches the index. An I/O write to port 24h stores the data into the indexed register. An I/O read at port 24h returns that register on `ioRdData` in the same cycle. Any other I/O read returns 0.
- R3: Register 23h bits 0..7 enable shadowing of blocks D0000h, D4000h, D8000h, DC000h, E0000h, E4000h, E8000h and EC000h, in that order. Register 26h bits 0..3 do the same for C0000h, C4000h, C8000h and CC000h.
- R4: A valid window access goes to DRAM (`dramSel`=1) when its block's shadow bit is 1 and its segment's source selects memory. Otherwise it goes to the bus (`busSel`=1).
- R5: Segment source bits: register 22h bit 2 (D) and bit 3 (E) select memory when 1. Register 26h bit 5 (C) selects memory when 0 and bus ROM when 1.
- R6: Read-only bits are register 22h bit 0 (D), register 22h bit 1 (E) and register 26h bit 4 (C), where 1 means read-only. A write that would go to DRAM in a read-only segment raises `wrInhibit`, and neither select is raised. Reads of such a segment still go to DRAM. Writes routed to the bus are not affected.
- R7: An access outside C0000h–EFFFFh raises none of `dramSel`, `busSel` or `wrInhibit`.
- R8: An index other than 22h, 23h or 26h reads back 0, and writes to it change no register. Undefined bits (22h bits 7..4, 26h bits 7..6) read back 0.
- R9: With `memValid` low, all three routing outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioWrEn | input | 1 | I/O write strobe |
| ioRdEn | input | 1 | I/O read strobe |
| ioAddr | input | 16 | I/O port address |
| ioWrData | input | 8 | I/O write data |
| ioRdData | output | 8 | I/O read data |
| memValid | input | 1 | A memory cycle is present |
| memAddr | input | 20 | Memory address |
| memWrite | input | 1 | 1 for a write cycle, 0 for a read cycle |
| dramSel | output | 1 | Access is served by local DRAM |
| busSel | output | 1 | Access is passed to the expansion bus |
| wrInhibit | output | 1 | Write to a read-only shadowed block was dropped |

## Verification
The bench runs a series of configuration patterns. Under each pattern it probes the first and last byte of all twelve blocks, as both reads and writes, and also probes addresses just outside both edges of the window. A block index off by one, or a shadow register with its bits reversed, would send the edge blocks of a segment to the wrong target. A C source bit with the wrong polarity would route the whole C segment the wrong way. A read-only check that also covered reads, or that also covered bus-routed writes, would raise `wrInhibit` where it must stay low. Writes to undefined indices, followed by readback of every register, catch a decoder that aliases an unused index onto a real register.

// File: rtl/shadowPkg.sv
package shadowPkg;
  localparam int unsigned NUM_SEG     = 3;
  localparam int unsigned BLK_PER_SEG = 4;
  localparam int unsigned NUM_BLK     = NUM_SEG * BLK_PER_SEG;
  localparam int unsigned BLK_AW      = 14;

  localparam logic [7:0] IDX_SEGCTL = 8'h22;
  localparam logic [7:0] IDX_SHDE   = 8'h23;
  localparam logic [7:0] IDX_SHC    = 8'h26;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_SEGCTL = 2'd1,
    RD_SHDE   = 2'd2,
    RD_SHC    = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic       wrSegCtl;
    logic       wrShadowDe;
    logic       wrShadowC;
    rdSel_e     rdSel;
    logic [7:0] data;
  } cfgStrobe_t;
endpackage

// File: rtl/shadowCfgCtl.sv
module shadowCfgCtl
  import shadowPkg::*;
#(
  parameter int unsigned IO_AW = 16,
  parameter logic [IO_AW-1:0] INDEX_PORT = 16'h0022,
  parameter logic [IO_AW-1:0] DATA_PORT  = 16'h0024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioWrEn,
  input  logic             ioRdEn,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic [7:0]       ioWrData,
  output cfgStrobe_t       strobe
);
  logic [7:0] idxReg;
  logic       idxHit;
  logic       dataHit;

  assign idxHit  = ioWrEn && (ioAddr == INDEX_PORT);
  assign dataHit = (ioAddr == DATA_PORT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       idxReg <= '0;
    else if (idxHit) idxReg <= ioWrData;
  end

  always_comb begin
    strobe            = '0;
    strobe.data       = ioWrData;
    strobe.rdSel      = RD_NONE;
    strobe.wrSegCtl   = ioWrEn && dataHit && (idxReg == IDX_SEGCTL);
    strobe.wrShadowDe = ioWrEn && dataHit && (idxReg == IDX_SHDE);
    strobe.wrShadowC  = ioWrEn && dataHit && (idxReg == IDX_SHC);
    if (ioRdEn && dataHit) begin
      unique case (idxReg)
        IDX_SEGCTL: strobe.rdSel = RD_SEGCTL;
        IDX_SHDE:   strobe.rdSel = RD_SHDE;
        IDX_SHC:    strobe.rdSel = RD_SHC;
        default:    strobe.rdSel = RD_NONE;
      endcase
    end
  end

  // R2: the index only moves on a write to the index port
  a_r2_index_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(ioWrEn && ioAddr == INDEX_PORT) |=> $stable(idxReg));

  // R8: at most one register write strobe per cycle
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrSegCtl, strobe.wrShadowDe, strobe.wrShadowC}));
endmodule

// File: rtl/shadowDatapath.sv
module shadowDatapath
  import shadowPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strobe,
  output logic [7:0] ioRdData,
  input  logic       memValid,
  input  logic [19:0] memAddr,
  input  logic       memWrite,
  output logic       dramSel,
  output logic       busSel,
  output logic       wrInhibit
);
  localparam int unsigned SEG_W = $clog2(NUM_SEG + 1);
  localparam int unsigned BLK_W = $clog2(NUM_BLK);

  logic [3:0] segCtl;
  logic [7:0] shDe;
  logic [5:0] shC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segCtl <= '0;
      shDe   <= '0;
      shC    <= '0;
    end else begin
      if (strobe.wrSegCtl)   segCtl <= strobe.data[3:0];
      if (strobe.wrShadowDe) shDe   <= strobe.data;
      if (strobe.wrShadowC)  shC    <= strobe.data[5:0];
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_SEGCTL: ioRdData = {4'b0, segCtl};
      RD_SHDE:   ioRdData = shDe;
      RD_SHC:    ioRdData = {2'b0, shC};
      default:   ioRdData = 8'h00;
    endcase
  end

  // Per-segment controls, index 0 = C, 1 = D, 2 = E
  logic [NUM_BLK-1:0] shadowVec;
  logic [NUM_SEG-1:0] segRo;
  logic [NUM_SEG-1:0] segMem;

  assign shadowVec = {shDe, shC[BLK_PER_SEG-1:0]};

  generate
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      if (s == 0) begin : g_cseg
        assign segRo[s]  = shC[4];
        assign segMem[s] = ~shC[5];
      end else begin : g_deseg
        assign segRo[s]  = segCtl[s-1];
        assign segMem[s] = segCtl[s+1];
      end
    end
  endgenerate

  logic [SEG_W-1:0] segIdx;
  logic [BLK_W-1:0] blkIdx;
  logic             inWin;
  logic             toDram;
  logic             blocked;

  assign segIdx  = SEG_W'(memAddr[17:16]);
  assign blkIdx  = {memAddr[17:16], memAddr[15:BLK_AW]};
  assign inWin   = memValid && (memAddr[19:18] == 2'b11) && (memAddr[17:16] != 2'b11);
  assign toDram  = inWin && shadowVec[blkIdx] && segMem[segIdx];
  assign blocked = toDram && memWrite && segRo[segIdx];

  assign dramSel   = toDram && !blocked;
  assign wrInhibit = blocked;
  assign busSel    = inWin && !toDram;

  // R1: reset leaves every block unshadowed
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (shadowVec == '0 && segCtl == '0));

  // R4: at most one routing outcome per access
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dramSel, busSel, wrInhibit}));

  // R6: inhibit only on a write cycle
  a_r6_inhibit_write: assert property (@(posedge clk) disable iff (!rstN)
    wrInhibit |-> (memWrite && memValid));

  // R7: outside the window nothing is asserted
  a_r7_outside_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (memAddr[19:18] != 2'b11 || memAddr[17:16] == 2'b11) |-> !(dramSel || busSel || wrInhibit));

  // R9: idle cycles are quiet
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !memValid |-> !(dramSel || busSel || wrInhibit));

  // R8: registers only change on their own strobe
  a_r8_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrSegCtl || strobe.wrShadowDe || strobe.wrShadowC) |=> $stable({segCtl, shDe, shC}));
endmodule

// File: rtl/shadowRouter.sv
module shadowRouter
  import shadowPkg::*;
#(
  parameter int unsigned IO_AW = 16,
  parameter logic [IO_AW-1:0] INDEX_PORT = 16'h0022,
  parameter logic [IO_AW-1:0] DATA_PORT  = 16'h0024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioWrEn,
  input  logic             ioRdEn,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic [7:0]       ioWrData,
  output logic [7:0]       ioRdData,
  input  logic             memValid,
  input  logic [19:0]      memAddr,
  input  logic             memWrite,
  output logic             dramSel,
  output logic             busSel,
  output logic             wrInhibit
);
  cfgStrobe_t strobe;

  shadowCfgCtl #(
    .IO_AW(IO_AW), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioAddr(ioAddr), .ioWrData(ioWrData), .strobe(strobe)
  );

  shadowDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ioRdData(ioRdData),
    .memValid(memValid), .memAddr(memAddr), .memWrite(memWrite),
    .dramSel(dramSel), .busSel(busSel), .wrInhibit(wrInhibit)
  );
endmodule

// File: tb/shadowRouter_tb.sv
module shadowRouter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioWrEn = 1'b0;
  logic        ioRdEn = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic        memValid = 1'b0;
  logic [19:0] memAddr = '0;
  logic        memWrite = 1'b0;
  logic        dramSel, busSel, wrInhibit;

  int vecCount = 0;
  int errCount = 0;
  bit done = 1'b0;

  shadowRouter u_dut (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .memValid(memValid), .memAddr(memAddr),
    .memWrite(memWrite), .dramSel(dramSel), .busSel(busSel), .wrInhibit(wrInhibit)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vecCount++;
    if (got !== exp) begin
      errCount++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic cfgWrite(input logic [7:0] idx, input logic [7:0] d);
    ioWrite(16'h0022, idx);
    ioWrite(16'h0024, d);
  endtask

  task automatic cfgRead(input logic [7:0] idx, output logic [7:0] d);
    ioWrite(16'h0022, idx);
    ioAddr = 16'h0024; ioRdEn = 1'b1;
    #1 d = ioRdData;
    ioRdEn = 1'b0;
  endtask

  // expected {dramSel, busSel, wrInhibit}
  function automatic logic [2:0] expRoute(input logic [19:0] a, input logic w, input logic v,
                                          input logic [7:0] sc, input logic [7:0] de,
                                          input logic [7:0] cc);
    int blk, seg;
    logic sh, mem, ro;
    if (!v || a < 20'hC0000 || a > 20'hEFFFF) return 3'b000;
    blk = int'(a >> 14) - 48;
    seg = blk / 4;
    sh  = (blk < 4) ? cc[blk] : de[blk - 4];
    mem = (seg == 0) ? !cc[5] : (seg == 1) ? sc[2] : sc[3];
    ro  = (seg == 0) ? cc[4]  : (seg == 1) ? sc[0] : sc[1];
    if (!(sh && mem)) return 3'b010;
    if (w && ro) return 3'b001;
    return 3'b100;
  endfunction

  task automatic probe(input string tag, input logic [19:0] a, input logic w, input logic v,
                       input logic [7:0] sc, input logic [7:0] de, input logic [7:0] cc);
    logic [2:0] exp;
    @(negedge clk);
    memAddr = a; memWrite = w; memValid = v;
    #1;
    exp = expRoute(a, w, v, sc, de, cc);
    check($sformatf("%s addr=%h wr=%0d", tag, a, w), {5'b0, dramSel, busSel, wrInhibit}, {5'b0, exp});
    memValid = 1'b0;
  endtask

  task automatic sweep(input logic [7:0] sc, input logic [7:0] de, input logic [7:0] cc);
    for (int b = 0; b < 12; b++) begin
      for (int o = 0; o < 2; o++) begin
        for (int w = 0; w < 2; w++) begin
          logic [19:0] a;
          a = 20'hC0000 + 20'(b * 16384) + (o == 1 ? 20'h3FFF : 20'h0);
          probe("R3 R4 R5 R6 route", a, w[0], 1'b1, sc, de, cc);
        end
      end
    end
    for (int w = 0; w < 2; w++) begin
      probe("R7 below window", 20'hBFFFF, w[0], 1'b1, sc, de, cc);
      probe("R7 above window", 20'hF0000, w[0], 1'b1, sc, de, cc);
      probe("R7 low memory", 20'h00000, w[0], 1'b1, sc, de, cc);
    end
    probe("R9 idle", 20'hD4000, 1'b0, 1'b0, sc, de, cc);
  endtask

  initial begin
    logic [7:0] rd;
    logic [7:0] sc, de, cc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    cfgRead(8'h22, rd); check("R1 reg22 reset", rd, 8'h00);
    cfgRead(8'h23, rd); check("R1 reg23 reset", rd, 8'h00);
    cfgRead(8'h26, rd); check("R1 reg26 reset", rd, 8'h00);
    sweep(8'h00, 8'h00, 8'h00);

    // R2 non-data-port read returns 0
    cfgWrite(8'h23, 8'hA5);
    @(negedge clk); ioAddr = 16'h0022; ioRdEn = 1'b1;
    #1 check("R2 index port read", ioRdData, 8'h00);
    ioRdEn = 1'b0;
    cfgRead(8'h23, rd); check("R2 reg23 readback", rd, 8'hA5);

    for (int p = 0; p < 40; p++) begin
      if (p == 0) begin sc = 8'hFF; de = 8'hFF; cc = 8'hFF; end
      else if (p == 1) begin sc = 8'h0C; de = 8'hFF; cc = 8'h0F; end
      else if (p == 2) begin sc = 8'h0F; de = 8'h81; cc = 8'h19; end
      else begin
        sc = 8'((p * 53 + 7) & 255);
        de = 8'((p * 29 + p * p) & 255);
        cc = 8'((p * 71 + 3) & 255);
      end
      cfgWrite(8'h22, sc);
      cfgWrite(8'h23, de);
      cfgWrite(8'h26, cc);
      // R8 undefined indices ignored
      cfgWrite(8'h21, 8'hFF);
      cfgWrite(8'h27, 8'h00);
      cfgWrite(8'h2B, ~sc);
      cfgRead(8'h22, rd); check("R2 R8 reg22 readback", rd, sc & 8'h0F);
      cfgRead(8'h23, rd); check("R2 reg23 readback", rd, de);
      cfgRead(8'h26, rd); check("R2 R8 reg26 readback", rd, cc & 8'h3F);
      cfgRead(8'h21, rd); check("R8 undefined index read", rd, 8'h00);
      sweep(sc & 8'h0F, de, cc & 8'h3F);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end
endmodule